// File: doc/BRIEF.md
# DMA Interrupt and Bus-Error Status Block

This block collects the interrupt sources of one DMA channel into a small word-addressed register file. The datapath hands it two single-cycle event pulses: one when a transfer needs attention, one when a bus access fails. With the failure pulse comes the address that faulted. Each pulse sets a pending flag. Software turns sources on through a write-one-to-set enable register and acknowledges them through a separate write-one-to-clear register. The block drives one level-sensitive interrupt line.

When the first bus error arrives while no error is pending, the block stores the 64-bit failing address. Software reads it back as a low word and a high word. Later errors leave the stored address alone until software acknowledges the error flag. A read port returns any register in the same cycle from a word index. Writes take effect at the next rising clock edge.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, all pending bits, all enable bits and the captured address are zero, and `irq_o` is low.
- R2: An `evt_i` pulse sets the matching pending bit at the next clock edge. Bit 0 is the transfer interrupt and bit 1 is the bus error. The pending bits read back at word index 3.
- R3: A write to word index 7 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R4: A write to word index 5 sets each enable bit whose data bit is 1. Data bits that are 0 have no effect. Enables read back at word index 5, and only reset clears them.
- R5: `irq_o` is high exactly when some source is both pending and enabled. It follows the registered state with no added delay.
- R6: If an event and a clear hit the same pending bit in the same cycle, the bit stays set.
- R7: A bus error that arrives while pending bit 1 is clear stores `err_addr_i`. Bits 31:0 read at word index 0 and bits 63:32 read at word index 1.
- R8: A bus error that arrives while pending bit 1 is already set leaves the stored address unchanged. After bit 1 is cleared, the next error stores a new address.
- R9: Pending bits are set and read back whatever the enables are. Masking acts only on `irq_o`.
- R10: Word indices 2, 4, 6 and 7 read as zero. So does any other unmapped index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 2 | Event pulses: bit 0 transfer, bit 1 bus error |
| err_addr_i | input | 64 | Failing bus address, sampled with `evt_i[1]` |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Word index of the write |
| wr_data_i | input | 32 | Write data |
| rd_idx_i | input | 3 | Word index of the read |
| rd_data_o | output | 32 | Read data, combinational from `rd_idx_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
Every write and every event pulse changes state at the first rising edge after it is presented. Read data and `irq_o` are combinational from that state, so each result is due one edge after its stimulus. The bench drives inputs on the falling edge and releases them on the next falling edge. It samples shortly after that second falling edge, with the one intervening rising edge already applied. The enable and pending patterns are swept in full, four of each, and `irq_o` and the status word are computed arithmetically for each pair.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned ERR_BIT = 1;

  localparam logic [IDX_W-1:0] IDX_ADDR_LO = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR_HI = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_EN_SET  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_CLEAR   = 3'd7;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] set_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic pend_r, en_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           pend_r <= 1'b0;
      else if (evt_i[g])     pend_r <= 1'b1;  // event beats clear
      else if (clr_i[g])     pend_r <= 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           en_r <= 1'b0;
      else if (set_en_i[g])  en_r <= 1'b1;
    end
    assign pend_o[g] = pend_r;
    assign en_o[g]   = en_r;

    p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> pend_o[g]);
    p_clr_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !evt_i[g]) |=> !pend_o[g]);
    p_en_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[g] |=> en_o[g]);
    p_collide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[g] && clr_i[g]) |=> pend_o[g]);
  end
endmodule

// File: rtl/err_addr_capture.sv
module err_addr_capture #(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          err_evt_i,
  input  logic          err_pend_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cap_o <= '0;
    else if (err_evt_i && !err_pend_i)  cap_o <= addr_i;
  end

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt_i && !err_pend_i) |=> (cap_o == $past(addr_i)));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pend_i |=> $stable(cap_o));
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
  import dma_irq_pkg::*;
#(
  parameter int unsigned N  = 2,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 64
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     en_i,
  input  logic [AW-1:0]    cap_i,
  output logic [DW-1:0]    data_o
);
  localparam int unsigned HI_W = AW - DW;
  logic [DW-1:0] hi_word;
  assign hi_word = DW'(cap_i[AW-1:DW]);

  always_comb begin
    unique case (idx_i)
      IDX_ADDR_LO: data_o = cap_i[DW-1:0];
      IDX_ADDR_HI: data_o = hi_word;
      IDX_STATUS:  data_o = {{(DW-N){1'b0}}, pend_i};
      IDX_EN_SET:  data_o = {{(DW-N){1'b0}}, en_i};
      default:     data_o = '0;
    endcase
  end

  initial assert (HI_W > 0 && HI_W <= DW);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] set_vec, clr_vec, pend, en;
  logic [ADDR_W-1:0]  cap;

  assign set_vec = (wr_en_i && wr_idx_i == IDX_EN_SET) ? wr_data_i[NUM_SRC-1:0] : '0;
  assign clr_vec = (wr_en_i && wr_idx_i == IDX_CLEAR)  ? wr_data_i[NUM_SRC-1:0] : '0;

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk_i, .rst_ni, .evt_i,
    .set_en_i(set_vec), .clr_i(clr_vec),
    .pend_o(pend), .en_o(en)
  );

  err_addr_capture #(.AW(ADDR_W)) u_cap (
    .clk_i, .rst_ni,
    .err_evt_i(evt_i[ERR_BIT]), .err_pend_i(pend[ERR_BIT]),
    .addr_i(err_addr_i), .cap_o(cap)
  );

  reg_read_mux #(.N(NUM_SRC), .DW(DATA_W), .AW(ADDR_W)) u_rd (
    .idx_i(rd_idx_i), .pend_i(pend), .en_i(en), .cap_i(cap), .data_o(rd_data_o)
  );

  assign irq_o = |(pend & en);

  p_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  p_unmasked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[0] && en[0]) |=> irq_o);
endmodule

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  evt = '0;
  logic [63:0] eaddr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_irq_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .err_addr_i(eaddr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .irq_o(irq)
  );

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    rd_idx = idx; #1; d = rd_data;
  endtask

  task automatic step(input logic [1:0] e, input logic we, input logic [2:0] wi,
                      input logic [31:0] wd, input logic [63:0] a);
    @(negedge clk);
    evt = e; wr_en = we; wr_idx = wi; wr_data = wd; eaddr = a;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; #1;
  endtask

  logic [31:0] d;

  initial begin
    do_reset();
    rd(3'd3, d); chk("R1 status", d, 0);
    rd(3'd5, d); chk("R1 enable", d, 0);
    rd(3'd0, d); chk("R1 addr lo", d, 0);
    rd(3'd1, d); chk("R1 addr hi", d, 0);
    chk("R1 irq", irq, 0);

    // sweep enables x pending (R2 R4 R5 R9)
    for (int e = 0; e < 4; e++) begin
      do_reset();
      step(2'b00, 1'b1, 3'd5, 32'(e), '0);
      rd(3'd5, d); chk("R4 enable readback", d, e);
      for (int p = 0; p < 4; p++) begin
        step(2'b00, 1'b1, 3'd7, 32'h3, '0);
        step(2'(p), 1'b0, 3'd0, 32'h0, 64'h0);
        rd(3'd3, d); chk("R2 R9 status", d, p);
        chk("R5 irq", irq, 64'((p & e) != 0));
      end
    end

    // R4: zero bits do nothing
    do_reset();
    step(2'b00, 1'b1, 3'd5, 32'h0, '0);
    rd(3'd5, d); chk("R4 zero write", d, 0);
    step(2'b00, 1'b1, 3'd5, 32'h2, '0);
    step(2'b00, 1'b1, 3'd5, 32'h1, '0);
    rd(3'd5, d); chk("R4 accumulate", d, 3);
    step(2'b00, 1'b1, 3'd7, 32'h3, '0);
    rd(3'd5, d); chk("R4 clear leaves enable", d, 3);

    // R3 partial clear
    step(2'b01, 1'b0, 3'd0, 0, 64'h0);
    step(2'b10, 1'b0, 3'd0, 0, 64'h0);
    step(2'b00, 1'b1, 3'd7, 32'h0, '0);
    rd(3'd3, d); chk("R3 zero clear", d, 3);
    step(2'b00, 1'b1, 3'd7, 32'h1, '0);
    rd(3'd3, d); chk("R3 clear bit0", d, 2);
    step(2'b00, 1'b1, 3'd7, 32'h2, '0);
    rd(3'd3, d); chk("R3 clear bit1", d, 0);
    chk("R3 irq low", irq, 0);

    // R6 collision
    step(2'b01, 1'b0, 3'd0, 0, 64'h0);
    step(2'b01, 1'b1, 3'd7, 32'h3, '0);
    rd(3'd3, d); chk("R6 event wins", d, 1);
    step(2'b00, 1'b1, 3'd7, 32'h3, '0);

    // R7 R8 capture
    do_reset();
    step(2'b10, 1'b0, 3'd0, 0, 64'h1234_5678_9abc_def0);
    rd(3'd0, d); chk("R7 addr lo", d, 32'h9abc_def0);
    rd(3'd1, d); chk("R7 addr hi", d, 32'h1234_5678);
    step(2'b10, 1'b0, 3'd0, 0, 64'hffff_0000_ffff_0000);
    rd(3'd0, d); chk("R8 hold lo", d, 32'h9abc_def0);
    step(2'b10, 1'b1, 3'd7, 32'h2, 64'h5555_0000_0000_5555);
    rd(3'd1, d); chk("R8 collision hold hi", d, 32'h1234_5678);
    step(2'b00, 1'b1, 3'd7, 32'h2, '0);
    step(2'b10, 1'b0, 3'd0, 0, 64'hcafe_f00d_0bad_beef);
    rd(3'd0, d); chk("R8 recapture lo", d, 32'h0bad_beef);
    rd(3'd1, d); chk("R8 recapture hi", d, 32'hcafe_f00d);

    // R10 unmapped reads
    step(2'b00, 1'b1, 3'd5, 32'h3, '0);
    foreach (d[i]) begin end
    rd(3'd2, d); chk("R10 idx2", d, 0);
    rd(3'd4, d); chk("R10 idx4", d, 0);
    rd(3'd6, d); chk("R10 idx6", d, 0);
    rd(3'd7, d); chk("R10 idx7", d, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule